// File: doc/BRIEF.md
# Non-Blocking Read-Only Cache Lane

This block is one lane of a read-only cache that serves reference pixel lines. A request carries a line address. The lane splits it into a direct-mapped index (the low bits) and a tag (the remaining bits) and looks it up in a tag register file. Every accepted request, hit or miss, enters a read queue that feeds the data SRAM. Each miss also enters an outstanding-miss queue. That queue issues line fetches on a memory port whose response latency varies. Because the cache is read-only, nothing is ever written back.

On a miss the tag is overwritten at the moment the request is accepted, which is before the fetch is issued. A later request to the same line therefore counts as a hit and produces no second fetch. Each line also has a "present" flag. A miss clears the flag and the fill sets it again. The head of the read queue waits until the flag of its line is set. Each line keeps a count of queued reads that still refer to it. A miss that would evict a line with a nonzero count is held off, so that a line cannot be replaced under a pending read. Read data comes out in the order the requests were accepted, at most one word per cycle.

Top module: `cache_lane`

## Requirements
- R1: After reset every tag is invalid, `req_ready` is 1, and `mem_req_valid` and `rd_valid` are 0.
- R2: Each accepted miss issues exactly one fetch on `mem_req_line`. Fetches go out in the order the misses were accepted. A fetch that is not yet taken holds its line stable.
- R3: A request whose tag matches the stored tag of its index is a hit, even if the fill for that line is still in flight. A hit issues no fetch.
- R4: `rd_data` returns the content of the requested line. Words come out in the order the requests were accepted, with at most one word per cycle, each marked by `rd_valid`.
- R5: A queued read whose line has not yet been filled is not delivered until the fill has been written. Memory latency of any length still gives correct data.
- R6: Memory responses arrive in fetch order. Each one is written into the index recorded with the oldest unanswered fetch.
- R7: While the read queue holds 32 entries, `req_ready` is 0.
- R8: While 8 fetches are unanswered, `req_ready` is 0.
- R9: A miss to an index that still has queued reads is not accepted (`req_ready` is 0) until those reads have left the queue.
- R10: The index is `req_line[3:0]` and the tag is `req_line[11:4]`. A miss with a different tag replaces the line, so returning to the old line fetches it again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Lane can accept the request this cycle |
| req_line | input | 12 | Requested line address (tag and index) |
| mem_req_valid | output | 1 | Line fetch pending |
| mem_req_ready | input | 1 | Memory takes the fetch |
| mem_req_line | output | 12 | Line address of the fetch |
| mem_rsp_valid | input | 1 | Fill data for the oldest unanswered fetch |
| mem_rsp_data | input | 32 | Fill data |
| rd_valid | output | 1 | Read word valid |
| rd_data | output | 32 | Read word |

## Verification
A request is accepted at a clock edge. At the earliest, its fetch appears on `mem_req_valid` after the next edge. The head of the read queue pops in the cycle after its line's present flag is set, which is one edge after the fill response. The word then shows on `rd_data` one edge after the pop. These delays depend on queue depth and random memory latency, so the bench samples every port on the falling edge. It matches fetches and read words against ordered lists of expected values built at acceptance time, not against fixed cycle offsets. The full-queue and eviction stalls are checked by looking at `req_ready` on the falling edge after the blocking state has been set up with memory responses held back.

// File: rtl/cl_pkg.sv
`timescale 1ns/1ps
package cl_pkg;
  localparam int unsigned LINE_W_DEF   = 12;
  localparam int unsigned IDX_W_DEF    = 4;
  localparam int unsigned DATA_W_DEF   = 32;
  localparam int unsigned RQ_DEPTH_DEF = 32;
  localparam int unsigned MQ_DEPTH_DEF = 8;

  typedef enum logic [1:0] {
    LK_HIT   = 2'd0,
    LK_MISS  = 2'd1,
    LK_STALL = 2'd2
  } lookup_e;

  // circular pointer advance for a ring of 'depth' slots
  function automatic int unsigned ring_next(input int unsigned p, input int unsigned depth);
    return (p == depth - 1) ? 0 : p + 1;
  endfunction
endpackage

// File: rtl/cl_fifo.sv
`timescale 1ns/1ps
module cl_fifo
  import cl_pkg::*;
#(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 32,
  localparam int unsigned PW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic [PW:0]   count,
  output logic          full,
  output logic          empty
);
  logic [W-1:0]  store_q [DEPTH];
  logic [PW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [PW:0]   cnt_q, cnt_d;

  always_comb begin
    wp_d  = push ? PW'(ring_next(32'(wp_q), DEPTH)) : wp_q;
    rp_d  = pop  ? PW'(ring_next(32'(rp_q), DEPTH)) : rp_q;
    cnt_d = cnt_q + (PW+1)'(push) - (PW+1)'(pop);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) store_q[wp_q] <= din;
  end

  assign dout  = store_q[rp_q];
  assign count = cnt_q;
  assign full  = (cnt_q == (PW+1)'(DEPTH));
  assign empty = (cnt_q == '0);
endmodule

// File: rtl/cl_tag_file.sv
`timescale 1ns/1ps
module cl_tag_file
  import cl_pkg::*;
#(
  parameter int unsigned LINE_W   = LINE_W_DEF,
  parameter int unsigned IDX_W    = IDX_W_DEF,
  parameter int unsigned RQ_DEPTH = RQ_DEPTH_DEF,
  localparam int unsigned LINES   = 1 << IDX_W,
  localparam int unsigned TAG_W   = LINE_W - IDX_W,
  localparam int unsigned CW      = $clog2(RQ_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LINE_W-1:0] lk_line,
  output lookup_e           lk_kind,
  input  logic              acc,
  input  logic              fill_en,
  input  logic [IDX_W-1:0]  fill_idx,
  input  logic              rel_en,
  input  logic [IDX_W-1:0]  rel_idx,
  input  logic [IDX_W-1:0]  chk_idx,
  output logic              chk_rdy
);
  logic [TAG_W-1:0] tag_q [LINES];
  logic [CW-1:0]    ref_q [LINES];
  logic [LINES-1:0] vld_q, rdy_q;
  logic [IDX_W-1:0] lk_idx;
  logic [TAG_W-1:0] lk_tag;

  assign lk_idx = lk_line[IDX_W-1:0];
  assign lk_tag = lk_line[LINE_W-1:IDX_W];

  always_comb begin
    if (vld_q[lk_idx] && (tag_q[lk_idx] == lk_tag)) lk_kind = LK_HIT;
    else if (ref_q[lk_idx] != '0)                   lk_kind = LK_STALL;
    else                                            lk_kind = LK_MISS;
  end

  for (genvar i = 0; i < LINES; i++) begin : g_line
    logic             inc, dec, miss_here, vld_d, rdy_d, vld_r, rdy_r;
    logic [CW-1:0]    ref_d, ref_r;
    logic [TAG_W-1:0] tag_r;

    always_comb begin
      inc       = acc && (lk_idx == IDX_W'(i));
      miss_here = inc && (lk_kind == LK_MISS);
      dec       = rel_en && (rel_idx == IDX_W'(i));
      ref_d     = ref_r + CW'(inc) - CW'(dec);
      vld_d     = vld_r | miss_here;
      rdy_d     = rdy_r;
      if (fill_en && (fill_idx == IDX_W'(i))) rdy_d = 1'b1;
      else if (miss_here)                     rdy_d = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_r <= 1'b0;
        rdy_r <= 1'b0;
        ref_r <= '0;
      end else begin
        vld_r <= vld_d;
        rdy_r <= rdy_d;
        ref_r <= ref_d;
      end
    end

    // tag replaced when the miss is taken, ahead of the data
    always_ff @(posedge clk) begin
      if (miss_here) tag_r <= lk_tag;
    end

    assign vld_q[i] = vld_r;
    assign rdy_q[i] = rdy_r;
    assign ref_q[i] = ref_r;
    assign tag_q[i] = tag_r;
  end

  assign chk_rdy = rdy_q[chk_idx];
endmodule

// File: rtl/cl_miss_queue.sv
`timescale 1ns/1ps
module cl_miss_queue
  import cl_pkg::*;
#(
  parameter int unsigned LINE_W = LINE_W_DEF,
  parameter int unsigned IDX_W  = IDX_W_DEF,
  parameter int unsigned DEPTH  = MQ_DEPTH_DEF,
  localparam int unsigned PW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [LINE_W-1:0] push_line,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [LINE_W-1:0] mem_req_line,
  input  logic              rsp_valid,
  output logic              fill_en,
  output logic [IDX_W-1:0]  fill_idx,
  output logic [PW:0]       occ,
  output logic              full
);
  logic [LINE_W-1:0] store_q [DEPTH];
  logic [PW-1:0]     wp_q, wp_d, sp_q, sp_d, hp_q, hp_d;
  logic [PW:0]       occ_q, occ_d, pend_q, pend_d;
  logic              snd;

  always_comb begin
    snd     = mem_req_valid && mem_req_ready;
    fill_en = rsp_valid && (occ_q != pend_q);
    wp_d    = push    ? PW'(ring_next(32'(wp_q), DEPTH)) : wp_q;
    sp_d    = snd     ? PW'(ring_next(32'(sp_q), DEPTH)) : sp_q;
    hp_d    = fill_en ? PW'(ring_next(32'(hp_q), DEPTH)) : hp_q;
    occ_d   = occ_q  + (PW+1)'(push) - (PW+1)'(fill_en);
    pend_d  = pend_q + (PW+1)'(push) - (PW+1)'(snd);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q   <= '0;
      sp_q   <= '0;
      hp_q   <= '0;
      occ_q  <= '0;
      pend_q <= '0;
    end else begin
      wp_q   <= wp_d;
      sp_q   <= sp_d;
      hp_q   <= hp_d;
      occ_q  <= occ_d;
      pend_q <= pend_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) store_q[wp_q] <= push_line;
  end

  assign mem_req_valid = (pend_q != '0);
  assign mem_req_line  = store_q[sp_q];
  assign fill_idx      = store_q[hp_q][IDX_W-1:0];
  assign occ           = occ_q;
  assign full          = (occ_q == (PW+1)'(DEPTH));
endmodule

// File: rtl/cl_data_store.sv
`timescale 1ns/1ps
module cl_data_store
  import cl_pkg::*;
#(
  parameter int unsigned IDX_W  = IDX_W_DEF,
  parameter int unsigned DATA_W = DATA_W_DEF,
  localparam int unsigned LINES = 1 << IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] ram_q [LINES];
  logic              rv_q;
  logic [DATA_W-1:0] rd_q;

  always_ff @(posedge clk) begin
    if (wr_en) ram_q[wr_idx] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rd_en) rd_q <= ram_q[rd_idx];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rv_q <= 1'b0;
    else        rv_q <= rd_en;
  end

  assign rd_valid = rv_q;
  assign rd_data  = rd_q;
endmodule

// File: rtl/cache_lane.sv
`timescale 1ns/1ps
module cache_lane
  import cl_pkg::*;
#(
  parameter int unsigned LINE_W   = LINE_W_DEF,
  parameter int unsigned IDX_W    = IDX_W_DEF,
  parameter int unsigned DATA_W   = DATA_W_DEF,
  parameter int unsigned RQ_DEPTH = RQ_DEPTH_DEF,
  parameter int unsigned MQ_DEPTH = MQ_DEPTH_DEF,
  localparam int unsigned RQ_PW   = $clog2(RQ_DEPTH),
  localparam int unsigned MQ_PW   = $clog2(MQ_DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [LINE_W-1:0] req_line,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [LINE_W-1:0] mem_req_line,
  input  logic              mem_rsp_valid,
  input  logic [DATA_W-1:0] mem_rsp_data,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data
);
  lookup_e          lk_kind;
  logic             accept, miss_acc;
  logic             rq_full, rq_empty, rq_pop, head_rdy;
  logic [IDX_W-1:0] head_idx;
  logic [RQ_PW:0]   rq_cnt;
  logic             mq_full, fill_en;
  logic [IDX_W-1:0] fill_idx;
  logic [MQ_PW:0]   mq_occ;

  always_comb begin
    req_ready = !rq_full && !mq_full && (lk_kind != LK_STALL);
    accept    = req_valid && req_ready;
    miss_acc  = accept && (lk_kind == LK_MISS);
    rq_pop    = !rq_empty && head_rdy;
  end

  cl_tag_file #(.LINE_W(LINE_W), .IDX_W(IDX_W), .RQ_DEPTH(RQ_DEPTH)) u_tags (
    .clk(clk), .rst_n(rst_n),
    .lk_line(req_line), .lk_kind(lk_kind), .acc(accept),
    .fill_en(fill_en), .fill_idx(fill_idx),
    .rel_en(rq_pop), .rel_idx(head_idx),
    .chk_idx(head_idx), .chk_rdy(head_rdy)
  );

  cl_fifo #(.W(IDX_W), .DEPTH(RQ_DEPTH)) u_rdq (
    .clk(clk), .rst_n(rst_n),
    .push(accept), .din(req_line[IDX_W-1:0]),
    .pop(rq_pop), .dout(head_idx),
    .count(rq_cnt), .full(rq_full), .empty(rq_empty)
  );

  cl_miss_queue #(.LINE_W(LINE_W), .IDX_W(IDX_W), .DEPTH(MQ_DEPTH)) u_missq (
    .clk(clk), .rst_n(rst_n),
    .push(miss_acc), .push_line(req_line),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_line(mem_req_line),
    .rsp_valid(mem_rsp_valid), .fill_en(fill_en), .fill_idx(fill_idx),
    .occ(mq_occ), .full(mq_full)
  );

  cl_data_store #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_ram (
    .clk(clk), .rst_n(rst_n),
    .wr_en(fill_en), .wr_idx(fill_idx), .wr_data(mem_rsp_data),
    .rd_en(rq_pop), .rd_idx(head_idx),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );
endmodule

// File: rtl/cl_checker.sv
`timescale 1ns/1ps
module cl_checker #(
  parameter int unsigned LINE_W   = 12,
  parameter int unsigned RQ_DEPTH = 32,
  parameter int unsigned MQ_DEPTH = 8
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        req_ready,
  input logic                        mem_req_valid,
  input logic                        mem_req_ready,
  input logic [LINE_W-1:0]           mem_req_line,
  input logic                        rd_valid,
  input logic [$clog2(RQ_DEPTH):0]   rq_cnt,
  input logic [$clog2(MQ_DEPTH):0]   mq_occ
);
  AST_FETCH_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_line)); // R2

  AST_RDQ_FULL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (rq_cnt == ($clog2(RQ_DEPTH)+1)'(RQ_DEPTH)) |-> !req_ready); // R7

  AST_MISSQ_FULL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (mq_occ == ($clog2(MQ_DEPTH)+1)'(MQ_DEPTH)) |-> !req_ready); // R8

  AST_WORD_HAS_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(rq_cnt) != '0); // R4
endmodule

bind cache_lane cl_checker #(.LINE_W(LINE_W), .RQ_DEPTH(RQ_DEPTH), .MQ_DEPTH(MQ_DEPTH)) i_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready),
  .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
  .mem_req_line(mem_req_line), .rd_valid(rd_valid),
  .rq_cnt(rq_cnt), .mq_occ(mq_occ)
);

// File: tb/test_cache_lane.sv
`timescale 1ns/1ps
module test_cache_lane;
  localparam int LW = 12;
  localparam int IW = 4;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [LW-1:0] req_line = '0;
  logic          mem_req_valid;
  logic          mem_req_ready = 1'b0;
  logic [LW-1:0] mem_req_line;
  logic          mem_rsp_valid = 1'b0;
  logic [DW-1:0] mem_rsp_data = '0;
  logic          rd_valid;
  logic [DW-1:0] rd_data;

  cache_lane i_cache_lane (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_line(req_line), .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_line(mem_req_line), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .rd_valid(rd_valid), .rd_data(rd_data)
  );

  int n_vec = 0;
  int n_bad = 0;
  int cyc = 0;
  int last_due = 0;
  bit hold = 1'b0;

  logic [DW-1:0]    exp_rd[$];
  logic [LW-1:0]    exp_fetch[$];
  logic [LW-1:0]    mem_line[$];
  int               mem_due[$];
  logic [LW-IW-1:0] m_tag [16];
  bit               m_vld [16];

  always #10 clk = ~clk; // 50 MHz

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [DW-1:0] line_word(input logic [LW-1:0] l);
    return {l, 4'hA, ~l, 4'h5};
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // reference model, sampled on the falling edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (req_valid && req_ready) begin
        logic [IW-1:0]    ix;
        logic [LW-IW-1:0] tg;
        ix = req_line[IW-1:0];
        tg = req_line[LW-1:IW];
        exp_rd.push_back(line_word(req_line));
        if (!(m_vld[ix] && m_tag[ix] == tg)) begin
          exp_fetch.push_back(req_line);
          m_vld[ix] = 1'b1;
          m_tag[ix] = tg;
        end
      end
      if (mem_req_valid && mem_req_ready) begin
        int due;
        if (exp_fetch.size() == 0) check(1'b0, "R2/R3", 64'(mem_req_line), 64'hFFFF);
        else check(mem_req_line === exp_fetch.pop_front(), "R2/R3/R10", 64'(mem_req_line), 64'(line_word(mem_req_line) >> 20));
        due = cyc + 1 + int'($urandom_range(5));
        if (due <= last_due) due = last_due + 1;
        last_due = due;
        mem_line.push_back(mem_req_line);
        mem_due.push_back(due);
      end
      if (rd_valid) begin
        if (exp_rd.size() == 0) check(1'b0, "R4", 64'(rd_data), 64'hFFFF_FFFF);
        else begin
          logic [DW-1:0] e;
          e = exp_rd.pop_front();
          check(rd_data === e, "R4/R5/R6", 64'(rd_data), 64'(e));
        end
      end
    end
  end

  // memory model: in-order responses with variable latency
  always @(posedge clk) begin
    #1;
    if (!rst_n) begin
      mem_req_ready = 1'b0;
      mem_rsp_valid = 1'b0;
    end else begin
      mem_req_ready = hold ? 1'b1 : ($urandom_range(3) != 0);
      if (!hold && mem_line.size() > 0 && mem_due[0] <= cyc) begin
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = line_word(mem_line.pop_front());
        void'(mem_due.pop_front());
      end else begin
        mem_rsp_valid = 1'b0;
      end
    end
  end

  task automatic send(input logic [LW-1:0] l);
    req_valid = 1'b1;
    req_line  = l;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    #1;
    req_valid = 1'b0;
  endtask

  task automatic probe_blocked(input logic [LW-1:0] l, input string req);
    req_valid = 1'b1;
    req_line  = l;
    @(negedge clk);
    check(req_ready == 1'b0, req, 64'(req_ready), 64'd0);
    @(posedge clk);
    #1;
    req_valid = 1'b0;
  endtask

  task automatic drain();
    int guard = 0;
    while ((exp_rd.size() != 0 || exp_fetch.size() != 0 || mem_line.size() != 0) && guard < 5000) begin
      @(posedge clk);
      guard++;
    end
    repeat (3) @(posedge clk);
    #1;
  endtask

  initial begin
    wait (cyc >= 150000);
    check(1'b0, "R4 watchdog", 64'(cyc), 64'd0);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) m_vld[i] = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready == 1'b1, "R1 ready", 64'(req_ready), 64'd1);
    check(mem_req_valid == 1'b0, "R1 fetch", 64'(mem_req_valid), 64'd0);
    check(rd_valid == 1'b0, "R1 read", 64'(rd_valid), 64'd0);
    @(posedge clk);
    #1;

    // eviction hazard: R9, then refetch after replacement R10
    hold = 1'b1;
    send(12'h030);
    probe_blocked(12'h130, "R9");
    hold = 1'b0;
    send(12'h130);
    send(12'h030);
    drain();

    // in-flight hits and conflicts: R3, R5, R10
    send(12'h010);
    send(12'h010);
    send(12'h021);
    send(12'h010);
    send(12'h110);
    send(12'h010);
    send(12'h021);
    drain();

    // eight unanswered fetches: R8
    hold = 1'b1;
    for (int k = 0; k < 8; k++) send(12'h200 | 12'(k));
    repeat (4) @(posedge clk);
    #1;
    probe_blocked(12'h208, "R8");
    hold = 1'b0;
    drain();

    // read queue full behind one pending line: R7
    hold = 1'b1;
    for (int k = 0; k < 32; k++) send(12'h30A);
    probe_blocked(12'h30A, "R7");
    hold = 1'b0;
    drain();

    // mixed traffic with random latency: R2 R3 R4 R5 R6
    for (int k = 0; k < 400; k++) begin
      send({6'd0, 2'($urandom_range(3)), 4'($urandom_range(15))});
      if ($urandom_range(3) == 0) begin
        @(posedge clk);
        #1;
      end
    end
    drain();

    check(exp_rd.size() == 0, "R4 leftover words", 64'(exp_rd.size()), 64'd0);
    check(exp_fetch.size() == 0, "R2 leftover fetches", 64'(exp_fetch.size()), 64'd0);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule